// File: doc/BRIEF.md
# Access Violation Flag and Interrupt Unit

This block gathers access-violation pulses from the memory protection logic and keeps them as sticky flags. It also records the faulting address for each source and raises a single interrupt line. The sources fall into two banks. The non-owner bank holds seven sources: CPU read, CPU write, CPU fetch, DMA write, coprocessor read, coprocessor write and coprocessor fetch. The owner bank holds three sources: CPU fetch, CPU write and DMA write. Only the non-owner bank can reach the interrupt, and only through a per-source enable mask.

Software reaches the block through a simple register port. One request is sampled per clock. Writes take effect at the sampling edge. A read returns its data with a valid strobe one cycle later. The port sequencer has two named states. `PORT_IDLE` is entered whenever the sampled cycle holds no read. `PORT_RESP` is entered whenever the sampled cycle holds a read, and read data is presented while the sequencer is in this state. The transitions are `IDLE->RESP` and `RESP->RESP` on a read, and `RESP->IDLE` and `IDLE->IDLE` otherwise.

Register offsets (5-bit select):

| Offset | Name | Access | Layout |
|---|---|---|---|
| 0 | status view | read only | non-owner flags in bits 0..6, owner flags in bits 16..18 |
| 1 | enable mask | read/write | bits 0..6, one per non-owner source; other bits read as 0 |
| 2 | force | write only, reads as 0 | ones set flags; same layout as the status view |
| 3 | clear | write only, reads as 0 | ones clear flags; same layout as the status view |
| 16..22 | non-owner address | read only | faulting address of non-owner source 0..6, zero-extended |
| 24..26 | owner address | read only | faulting address of owner source 0..2, zero-extended |

Top module: `avf_unit`

## Requirements
- R1: After reset, every flag, every enable bit, every recorded address, the interrupt and the read-valid strobe are zero.
- R2: A hardware event pulse sets its flag at the next clock edge, and the flag then stays set. In the status view the non-owner bits 0 to 6 are, in order: CPU read, CPU write, CPU fetch, DMA write, coprocessor read, coprocessor write, coprocessor fetch. The owner bits 16, 17 and 18 are, in order: CPU fetch, CPU write, DMA write.
- R3: Writing to the clear register (offset 3) clears each flag whose bit is one and leaves the flags whose bit is zero unchanged.
- R4: When a hardware event for a source arrives in the same cycle as a clear write that names the same source, the flag remains set.
- R5: Writing to the force register (offset 2) sets each flag whose bit is one, in either bank.
- R6: The interrupt is high in a cycle exactly when some non-owner flag and its enable bit were both set in the previous cycle.
- R7: Owner flags never cause the interrupt, whatever the enable mask holds.
- R8: The address of a source is recorded only when a hardware event for that source arrives while its flag is clear. Later events leave the address unchanged until the flag has been cleared.
- R9: Setting a flag through the force register does not change that source's recorded address.
- R10: A read request produces the read-valid strobe and the read data exactly one cycle later. The data reflects the state in the request cycle. Writes produce no strobe, and unmapped or write-only offsets read as zero.
- R11: The enable mask (offset 1) reads back the bits written to positions 0 to 6, and bits 7 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nown_evt | input | 7 | Non-owner violation pulses, bit order as in R2 |
| nown_addr | input | AW | Faulting address carried with non-owner pulses |
| own_evt | input | 3 | Owner violation pulses: CPU fetch, CPU write, DMA write |
| own_addr | input | AW | Faulting address carried with owner pulses |
| reg_req | input | 1 | Register access request, sampled each clock |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 5 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| viol_irq | output | 1 | Registered violation interrupt |

## Verification
Three situations are hard to reach from the ports. One is a hardware pulse colliding with a clear write for the same source. Another is a second pulse arriving while the flag is already set. The third is a flag set by force rather than by a pulse. The stimulus drives pulse inputs and register requests in the same cycle to produce the collision. It repeats pulses with distinct addresses, and it forces flags whose address registers already hold known values. Each case is then read back through the status and address offsets. A behavioural reference model predicts the interrupt and every read response on every clock, so a timing slip of one cycle shows up as well as a wrong value.

// File: rtl/avf_pkg.sv
package avf_pkg;

    localparam int DW        = 32;
    localparam int SEL_W     = 5;
    localparam int NOWN_N    = 7;
    localparam int OWN_N     = 3;
    localparam int OWN_SHIFT = 16;

    localparam logic [SEL_W-1:0] OFF_STATUS = 5'd0;
    localparam logic [SEL_W-1:0] OFF_ENABLE = 5'd1;
    localparam logic [SEL_W-1:0] OFF_FORCE  = 5'd2;
    localparam logic [SEL_W-1:0] OFF_CLEAR  = 5'd3;
    localparam int               OFF_NADDR  = 16;
    localparam int               OFF_OADDR  = 24;

    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

endpackage

// File: rtl/avf_flag_bank.sv
module avf_flag_bank #(
    parameter int N  = 7,
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         hw_evt,
    input  logic [AW-1:0]        hw_addr,
    input  logic [N-1:0]         force_bits,
    input  logic [N-1:0]         clear_bits,
    output logic [N-1:0]         flags,
    output logic [N-1:0][AW-1:0] addrs
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_src
            logic flag_q;
            logic [AW-1:0] addr_q;
            logic first_hit;

            // A pulse that finds the flag clear is the first of its kind.
            assign first_hit = hw_evt[g] && !flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (hw_evt[g] || force_bits[g]) begin
                    flag_q <= 1'b1;      // setting wins over a coincident clear
                end else if (clear_bits[g]) begin
                    flag_q <= 1'b0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else if (first_hit) begin
                    addr_q <= hw_addr;
                end
            end

            assign flags[g] = flag_q;
            assign addrs[g] = addr_q;
        end
    endgenerate

endmodule

// File: rtl/avf_irq_gen.sv
module avf_irq_gen #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);

    logic pending;

    assign pending = |(flags & enables);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= pending;
        end
    end

endmodule

// File: rtl/avf_reg_port.sv
module avf_reg_port
    import avf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_req,
    input  logic                      reg_wr,
    input  logic [SEL_W-1:0]          reg_sel,
    input  logic [DW-1:0]             reg_wdata,
    input  logic [NOWN_N-1:0]         nown_flags,
    input  logic [OWN_N-1:0]          own_flags,
    input  logic [NOWN_N-1:0][AW-1:0] nown_addrs,
    input  logic [OWN_N-1:0][AW-1:0]  own_addrs,
    output logic [NOWN_N-1:0]         enables,
    output logic [NOWN_N-1:0]         force_nown,
    output logic [OWN_N-1:0]          force_own,
    output logic [NOWN_N-1:0]         clear_nown,
    output logic [OWN_N-1:0]          clear_own,
    output logic [DW-1:0]             reg_rdata,
    output logic                      reg_rvalid
);

    port_state_e state_q, state_d;
    logic read_now, write_now;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    logic [NOWN_N-1:0] en_q;

    assign read_now  = reg_req && !reg_wr;
    assign write_now = reg_req && reg_wr;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: state_d = read_now ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = read_now ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // Outputs of the sequencer.
    always_comb begin
        reg_rvalid = 1'b0;
        reg_rdata  = '0;
        unique case (state_q)
            PORT_IDLE: begin
                reg_rvalid = 1'b0;
                reg_rdata  = '0;
            end
            PORT_RESP: begin
                reg_rvalid = 1'b1;
                reg_rdata  = rdata_q;
            end
            default: begin
                reg_rvalid = 1'b0;
                reg_rdata  = '0;
            end
        endcase
    end

    // Read multiplexer over the current state.
    always_comb begin
        rd_mux = '0;
        if (reg_sel == OFF_STATUS) begin
            rd_mux = DW'(nown_flags) | (DW'(own_flags) << OWN_SHIFT);
        end else if (reg_sel == OFF_ENABLE) begin
            rd_mux = DW'(en_q);
        end
        for (int i = 0; i < NOWN_N; i++) begin
            if (reg_sel == SEL_W'(OFF_NADDR + i)) begin
                rd_mux = DW'(nown_addrs[i]);
            end
        end
        for (int k = 0; k < OWN_N; k++) begin
            if (reg_sel == SEL_W'(OFF_OADDR + k)) begin
                rd_mux = DW'(own_addrs[k]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (read_now) begin
            rdata_q <= rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (write_now && reg_sel == OFF_ENABLE) begin
            en_q <= reg_wdata[NOWN_N-1:0];
        end
    end

    assign enables = en_q;

    // Write strobes for the flag banks.
    always_comb begin
        force_nown = '0;
        force_own  = '0;
        clear_nown = '0;
        clear_own  = '0;
        if (write_now && reg_sel == OFF_FORCE) begin
            force_nown = reg_wdata[NOWN_N-1:0];
            force_own  = reg_wdata[OWN_SHIFT +: OWN_N];
        end
        if (write_now && reg_sel == OFF_CLEAR) begin
            clear_nown = reg_wdata[NOWN_N-1:0];
            clear_own  = reg_wdata[OWN_SHIFT +: OWN_N];
        end
    end

endmodule

// File: rtl/avf_unit.sv
module avf_unit
    import avf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NOWN_N-1:0] nown_evt,
    input  logic [AW-1:0]     nown_addr,
    input  logic [OWN_N-1:0]  own_evt,
    input  logic [AW-1:0]     own_addr,
    input  logic              reg_req,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_rvalid,
    output logic              viol_irq
);

    logic [NOWN_N-1:0]         nown_flags;
    logic [OWN_N-1:0]          own_flags;
    logic [NOWN_N-1:0][AW-1:0] nown_addrs;
    logic [OWN_N-1:0][AW-1:0]  own_addrs;
    logic [NOWN_N-1:0]         enables;
    logic [NOWN_N-1:0]         force_nown;
    logic [OWN_N-1:0]          force_own;
    logic [NOWN_N-1:0]         clear_nown;
    logic [OWN_N-1:0]          clear_own;

    avf_flag_bank #(.N(NOWN_N), .AW(AW)) u_nown_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_evt     (nown_evt),
        .hw_addr    (nown_addr),
        .force_bits (force_nown),
        .clear_bits (clear_nown),
        .flags      (nown_flags),
        .addrs      (nown_addrs)
    );

    avf_flag_bank #(.N(OWN_N), .AW(AW)) u_own_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_evt     (own_evt),
        .hw_addr    (own_addr),
        .force_bits (force_own),
        .clear_bits (clear_own),
        .flags      (own_flags),
        .addrs      (own_addrs)
    );

    avf_reg_port #(.AW(AW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_req    (reg_req),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .nown_flags (nown_flags),
        .own_flags  (own_flags),
        .nown_addrs (nown_addrs),
        .own_addrs  (own_addrs),
        .enables    (enables),
        .force_nown (force_nown),
        .force_own  (force_own),
        .clear_nown (clear_nown),
        .clear_own  (clear_own),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid)
    );

    // Only the non-owner bank feeds the interrupt.
    avf_irq_gen #(.N(NOWN_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (nown_flags),
        .enables (enables),
        .irq     (viol_irq)
    );

endmodule

// File: rtl/avf_checker.sv
module avf_checker
    import avf_pkg::*;
#(
    parameter int AW = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NOWN_N-1:0]         nown_evt,
    input logic [OWN_N-1:0]          own_evt,
    input logic [NOWN_N-1:0]         nown_flags,
    input logic [OWN_N-1:0]          own_flags,
    input logic [NOWN_N-1:0]         enables,
    input logic [NOWN_N-1:0]         clear_nown,
    input logic [NOWN_N-1:0][AW-1:0] nown_addrs,
    input logic                      reg_req,
    input logic                      reg_wr,
    input logic                      reg_rvalid,
    input logic                      viol_irq
);

    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|nown_evt) |=> ((nown_flags & $past(nown_evt)) == $past(nown_evt)));

    assert_owner_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|own_evt) |=> ((own_flags & $past(own_evt)) == $past(own_evt)));

    assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(nown_flags) & ~nown_flags) & ~$past(clear_nown)) == '0));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(nown_evt & clear_nown)) |=>
            ((nown_flags & $past(nown_evt & clear_nown)) == $past(nown_evt & clear_nown)));

    assert_owner_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nown_flags == '0) |=> !viol_irq);

    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(nown_flags & enables)) |=> viol_irq);

    assert_read_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr) |=> reg_rvalid);

    assert_no_write_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_wr) |=> !reg_rvalid);

    genvar g;
    generate
        for (g = 0; g < NOWN_N; g++) begin : g_addr_chk
            assert_addr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (nown_flags[g]) |=> $stable(nown_addrs[g]));
        end
    endgenerate

endmodule

bind avf_unit avf_checker #(.AW(AW)) u_avf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .nown_evt   (nown_evt),
    .own_evt    (own_evt),
    .nown_flags (nown_flags),
    .own_flags  (own_flags),
    .enables    (enables),
    .clear_nown (clear_nown),
    .nown_addrs (nown_addrs),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_rvalid (reg_rvalid),
    .viol_irq   (viol_irq)
);

// File: tb/tb_avf_unit.sv
module tb_avf_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  nown_evt = '0;
    logic [AW-1:0] nown_addr = '0;
    logic [2:0]  own_evt = '0;
    logic [AW-1:0] own_addr = '0;
    logic        reg_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        viol_irq;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    avf_unit #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .nown_evt(nown_evt), .nown_addr(nown_addr),
        .own_evt(own_evt), .own_addr(own_addr),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .viol_irq(viol_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model.
    logic [6:0]  m_nflag, m_en;
    logic [2:0]  m_oflag;
    logic [AW-1:0] m_naddr [7];
    logic [AW-1:0] m_oaddr [3];
    logic        m_irq, m_rvalid;
    logic [31:0] m_rdata;

    function automatic logic [31:0] model_read(input logic [4:0] s);
        int v;
        v = s;
        if (v == 0) return {13'd0, m_oflag, 9'd0, m_nflag};
        if (v == 1) return {25'd0, m_en};
        if (v >= 16 && v <= 22) return {16'd0, m_naddr[v-16]};
        if (v >= 24 && v <= 26) return {16'd0, m_oaddr[v-24]};
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        logic [6:0] fn, cn;
        logic [2:0] fo, co;
        if (!rst_n) begin
            m_nflag <= '0; m_oflag <= '0; m_en <= '0;
            m_irq <= 1'b0; m_rvalid <= 1'b0; m_rdata <= '0;
            for (int i = 0; i < 7; i++) m_naddr[i] <= '0;
            for (int i = 0; i < 3; i++) m_oaddr[i] <= '0;
        end else begin
            fn = '0; cn = '0; fo = '0; co = '0;
            m_rvalid <= reg_req && !reg_wr;
            if (reg_req && !reg_wr) m_rdata <= model_read(reg_sel);
            m_irq <= (m_nflag & m_en) != 0;
            if (reg_req && reg_wr && reg_sel == 5'd2) begin
                fn = reg_wdata[6:0]; fo = reg_wdata[18:16];
            end
            if (reg_req && reg_wr && reg_sel == 5'd3) begin
                cn = reg_wdata[6:0]; co = reg_wdata[18:16];
            end
            if (reg_req && reg_wr && reg_sel == 5'd1) m_en <= reg_wdata[6:0];
            for (int i = 0; i < 7; i++)
                if (nown_evt[i] && !m_nflag[i]) m_naddr[i] <= nown_addr;
            for (int i = 0; i < 3; i++)
                if (own_evt[i] && !m_oflag[i]) m_oaddr[i] <= own_addr;
            m_nflag <= (m_nflag & ~cn) | fn | nown_evt;
            m_oflag <= (m_oflag & ~co) | fo | own_evt;
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (viol_irq !== m_irq) begin
                failures++;
                $display("FAIL %s/R6 irq actual=%0b expected=%0b", tag, viol_irq, m_irq);
            end
            checks++;
            if (reg_rvalid !== m_rvalid) begin
                failures++;
                $display("FAIL R10 rvalid actual=%0b expected=%0b", reg_rvalid, m_rvalid);
            end
            if (m_rvalid) begin
                checks++;
                if (reg_rdata !== m_rdata) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, m_rdata);
                end
            end
        end
    end

    task automatic cyc(input logic [6:0] ne, input logic [AW-1:0] na,
                       input logic [2:0] oe, input logic [AW-1:0] oa,
                       input logic rq, input logic w, input logic [4:0] s,
                       input logic [31:0] d);
        nown_evt = ne; nown_addr = na; own_evt = oe; own_addr = oa;
        reg_req = rq; reg_wr = w; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        nown_evt = '0; own_evt = '0; reg_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] s);
        cyc('0, '0, '0, '0, 1'b1, 1'b0, s, '0);
    endtask

    task automatic wr(input logic [4:0] s, input logic [31:0] d);
        cyc('0, '0, '0, '0, 1'b1, 1'b1, s, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every readable location
        tag = "R1";
        rd(5'd0); rd(5'd1);
        for (int i = 16; i < 23; i++) rd(5'(i));
        for (int i = 24; i < 27; i++) rd(5'(i));
        idle(1);

        // R2: each source individually, check layout
        tag = "R2";
        for (int i = 0; i < 7; i++) begin
            cyc(7'(1 << i), 16'(16'h1000 + i), '0, '0, 1'b0, 1'b0, '0, '0);
            rd(5'd0);
        end
        for (int k = 0; k < 3; k++) begin
            cyc('0, '0, 3'(1 << k), 16'(16'h2000 + k), 1'b0, 1'b0, '0, '0);
            rd(5'd0);
        end
        for (int i = 16; i < 23; i++) rd(5'(i));
        for (int i = 24; i < 27; i++) rd(5'(i));

        // R3: partial clear
        tag = "R3";
        wr(5'd3, 32'h0005_0055);
        rd(5'd0);
        wr(5'd3, 32'h0007_007F);
        rd(5'd0);

        // R5 / R9: force both banks, addresses unchanged
        tag = "R5";
        wr(5'd2, 32'h0007_007F);
        rd(5'd0);
        tag = "R9";
        for (int i = 16; i < 23; i++) rd(5'(i));
        rd(5'd25);
        wr(5'd3, 32'h0007_007F);

        // R4: pulse collides with clear on the same bit
        tag = "R4";
        cyc(7'b0000100, 16'h3333, 3'b010, 16'h4444, 1'b1, 1'b1, 5'd3, 32'h0002_0004);
        rd(5'd0); rd(5'd18); rd(5'd25);
        wr(5'd3, 32'h0007_007F);

        // R6: enable mask gates the interrupt
        tag = "R6";
        cyc(7'b0001000, 16'h5555, '0, '0, 1'b0, 1'b0, '0, '0);
        idle(2);
        wr(5'd1, 32'h0000_0008);
        idle(3);
        wr(5'd1, 32'h0000_0001);
        idle(2);
        wr(5'd1, 32'h0000_0008);
        idle(1);
        wr(5'd3, 32'h0000_0008);
        idle(3);

        // R7: owner flags never interrupt
        tag = "R7";
        wr(5'd1, 32'h0000_007F);
        wr(5'd2, 32'h0007_0000);
        cyc('0, '0, 3'b111, 16'h6666, 1'b0, 1'b0, '0, '0);
        idle(4);
        rd(5'd0);
        wr(5'd3, 32'h0007_0000);

        // R8: first address preserved until clear
        tag = "R8";
        wr(5'd1, 32'h0);
        cyc(7'b0000001, 16'hAAAA, '0, '0, 1'b0, 1'b0, '0, '0);
        cyc(7'b0000001, 16'hBBBB, '0, '0, 1'b0, 1'b0, '0, '0);
        rd(5'd16);
        wr(5'd3, 32'h0000_0001);
        cyc(7'b0000001, 16'hCCCC, '0, '0, 1'b0, 1'b0, '0, '0);
        rd(5'd16);

        // R9: force over a cleared flag keeps the stale address
        tag = "R9";
        wr(5'd3, 32'h0000_0002);
        wr(5'd2, 32'h0000_0002);
        rd(5'd17); rd(5'd0);

        // R10: back-to-back reads, writes without strobe, unmapped offsets
        tag = "R10";
        rd(5'd2); rd(5'd3); rd(5'd5); rd(5'd31);
        wr(5'd0, 32'hFFFF_FFFF);
        rd(5'd0);
        idle(2);

        // R11: enable readback width
        tag = "R11";
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1);
        wr(5'd1, 32'h0000_0A5A);
        rd(5'd1);
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule